// File: doc/BRIEF.md
# FIFO Trigger Level and Ready Status Unit

This unit decides, every cycle, whether the transmit FIFO has room enough and whether the receive FIFO holds enough data to justify an interrupt or a DMA request. It compares the free-space count of the transmit FIFO and the character count of the receive FIFO with two trigger levels. The same two decisions appear as bits of a read-only ready status byte.

Each trigger level comes from one of two places. The first is a 4-bit code in an 8-bit level register, where a code N gives 4×N bytes. When that code is zero, the level comes from a fallback chosen by a 2-bit selection from the FIFO control logic. The level register is written through a small register bus, and only while two access-enable inputs are both high. The status byte sits at address 3'b111 and is visible only while the ready-status enable is set and loopback is off. At all other times a read of that address returns the data of the normal register there, which arrives on an input.

Top module: `fifo_trig_status`

## Requirements
- R1: After reset the level register reads 8'h00, so both trigger levels come from the fallback selections. A write attempted while reset is held is ignored.
- R2: A write to the level address (default 3'b110) updates the register on the clock edge only when `enh_func_en` and `ext_access_en` are both 1. Otherwise the stored value is unchanged.
- R3: Bits 3:0 of the level register hold the transmit code. A nonzero code N sets the transmit trigger level to 4×N free spaces, from 4 to 60.
- R4: Bits 7:4 of the level register hold the receive code. A nonzero code N sets the receive trigger level to 4×N characters, from 4 to 60.
- R5: A zero code falls back to the selection input. For transmit, `tx_fb_sel` 0/1/2/3 gives 8/16/32/56. For receive, `rx_fb_sel` 0/1/2/3 gives 8/16/56/60.
- R6: `tx_trig` is 1 exactly when `tx_free` is greater than or equal to the transmit trigger level.
- R7: `rx_trig` is 1 when `rx_used` is greater than or equal to the receive trigger level, or when `rx_timeout` is 1.
- R8: When `reg_addr` is 3'b111, `rdy_stat_en` is 1 and `loopback` is 0, `reg_rdata` returns the status byte: bit 0 = `tx_trig`, bit 4 = `rx_trig`, all other bits 0.
- R9: Any other read returns `ext_rdata`, with one exception. A read of the level address while both access enables are 1 returns the level register. Writes never change the status byte.
- R10: Both flags and the read data are combinational from the present inputs and register value. They follow a count change in the same cycle, without latching.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 3 | Register bus address |
| reg_we | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| ext_rdata | input | 8 | Read data of the normal register at the addressed location |
| reg_rdata | output | 8 | Read data |
| enh_func_en | input | 1 | Enhanced-function access enable |
| ext_access_en | input | 1 | Extended register access enable |
| rdy_stat_en | input | 1 | Ready-status read enable |
| loopback | input | 1 | Loopback mode active |
| tx_free | input | 7 | Free spaces in the transmit FIFO (0 to DEPTH) |
| rx_used | input | 7 | Characters stored in the receive FIFO (0 to DEPTH) |
| rx_timeout | input | 1 | Receive timeout condition |
| tx_fb_sel | input | 2 | Transmit fallback trigger selection |
| rx_fb_sel | input | 2 | Receive fallback trigger selection |
| tx_trig | output | 1 | Transmit trigger condition |
| rx_trig | output | 1 | Receive trigger condition |

## Verification
The hardest case to reach is a comparison boundary under a level taken from the register. A register level must first be written, which needs both access enables high. The counts must then sit exactly one below, at and one above the resulting level, and the boundary moves with every code. The stimulus walks every nonzero code of each field and probes the three counts around the level. It also walks every fallback selection with the code at zero. It then runs a long mixed phase in which writes land both while enabled and while blocked, with reads of the status and level addresses under every enable combination. A behavioural model checks all of this cycle by cycle.

// File: rtl/fts_pkg.sv
package fts_pkg;
   localparam int CODE_W = 4;
   localparam int LVL_W  = 8;
   localparam int SEL_W  = 2;
   localparam int N_SEL  = 1 << SEL_W;

   typedef struct packed {
      logic [CODE_W-1:0] rx_code;
      logic [CODE_W-1:0] tx_code;
   } lvl_reg_t;

   typedef enum logic {
      DIR_TX = 1'b0,
      DIR_RX = 1'b1
   } fts_dir_e;
endpackage

// File: rtl/fts_level_reg.sv
module fts_level_reg #(
   parameter int               ADDR_W   = 3,
   parameter logic [ADDR_W-1:0] LVL_ADDR = 3'b110
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               we,
   input  logic [ADDR_W-1:0]  addr,
   input  logic [7:0]         wdata,
   input  logic               acc_en,
   output fts_pkg::lvl_reg_t  lvl_q
);
   logic wr_hit;

   assign wr_hit = we && (addr == LVL_ADDR) && acc_en;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lvl_q <= '0;
      end else if (wr_hit) begin
         lvl_q <= fts_pkg::lvl_reg_t'(wdata);
      end
   end
endmodule

// File: rtl/fts_level_sel.sv
module fts_level_sel #(
   parameter logic [fts_pkg::N_SEL*fts_pkg::LVL_W-1:0] FB_TABLE = {8'd56, 8'd32, 8'd16, 8'd8}
) (
   input  logic [fts_pkg::CODE_W-1:0] code,
   input  logic [fts_pkg::SEL_W-1:0]  fb_sel,
   output logic [fts_pkg::LVL_W-1:0]  level
);
   localparam int PAD_W = fts_pkg::LVL_W - fts_pkg::CODE_W - 2;

   logic [fts_pkg::LVL_W-1:0] code_lvl;
   logic [fts_pkg::LVL_W-1:0] fb_lvl;

   assign code_lvl = {{PAD_W{1'b0}}, code, 2'b00};
   assign fb_lvl   = FB_TABLE[fb_sel*fts_pkg::LVL_W +: fts_pkg::LVL_W];

   always_comb begin
      if (code != '0) level = code_lvl;
      else            level = fb_lvl;
   end
endmodule

// File: rtl/fts_threshold.sv
module fts_threshold #(
   parameter int CNT_W = 7
) (
   input  logic [CNT_W-1:0]          count,
   input  logic [fts_pkg::LVL_W-1:0] level,
   input  logic                      force_hit,
   output logic                      hit
);
   localparam int CMP_W = (CNT_W > fts_pkg::LVL_W) ? CNT_W : fts_pkg::LVL_W;

   logic [CMP_W-1:0] cnt_x;
   logic [CMP_W-1:0] lvl_x;

   assign cnt_x = CMP_W'(count);
   assign lvl_x = CMP_W'(level);
   assign hit   = force_hit | (cnt_x >= lvl_x);
endmodule

// File: rtl/fifo_trig_status.sv
module fifo_trig_status #(
   parameter int                DEPTH       = 64,
   parameter int                ADDR_W      = 3,
   parameter logic [ADDR_W-1:0] LVL_ADDR    = 3'b110,
   parameter logic [ADDR_W-1:0] STAT_ADDR   = 3'b111,
   parameter logic [31:0]       TX_FALLBACK = {8'd56, 8'd32, 8'd16, 8'd8},
   parameter logic [31:0]       RX_FALLBACK = {8'd60, 8'd56, 8'd16, 8'd8},
   localparam int               CNT_W       = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic              reg_we,
   input  logic [7:0]        reg_wdata,
   input  logic [7:0]        ext_rdata,
   output logic [7:0]        reg_rdata,
   input  logic              enh_func_en,
   input  logic              ext_access_en,
   input  logic              rdy_stat_en,
   input  logic              loopback,
   input  logic [CNT_W-1:0]  tx_free,
   input  logic [CNT_W-1:0]  rx_used,
   input  logic              rx_timeout,
   input  logic [1:0]        tx_fb_sel,
   input  logic [1:0]        rx_fb_sel,
   output logic              tx_trig,
   output logic              rx_trig
);
   import fts_pkg::*;

   localparam int N_DIR    = 2;
   localparam int MAX_CODE = 4 * ((1 << CODE_W) - 1);

   // elaboration checks on the parameter set
   if (DEPTH < MAX_CODE) begin : g_chk_depth
      $error("fifo_trig_status: DEPTH must cover the largest coded level");
   end
   if (LVL_ADDR == STAT_ADDR) begin : g_chk_addr
      $error("fifo_trig_status: level and status addresses must differ");
   end
   for (genvar e = 0; e < N_SEL; e++) begin : g_chk_fb
      if (TX_FALLBACK[e*LVL_W +: LVL_W] == 0 || int'(TX_FALLBACK[e*LVL_W +: LVL_W]) > DEPTH) begin : g_tx_bad
         $error("fifo_trig_status: transmit fallback entry out of range");
      end
      if (RX_FALLBACK[e*LVL_W +: LVL_W] == 0 || int'(RX_FALLBACK[e*LVL_W +: LVL_W]) > DEPTH) begin : g_rx_bad
         $error("fifo_trig_status: receive fallback entry out of range");
      end
   end

   lvl_reg_t         lvl_q;
   logic             acc_en;
   logic [LVL_W-1:0] dir_lvl [N_DIR];
   logic [CNT_W-1:0] dir_cnt [N_DIR];
   logic             dir_hit [N_DIR];
   logic [LVL_W-1:0] tx_lvl;
   logic [LVL_W-1:0] rx_lvl;
   logic [7:0]       stat_byte;
   logic             stat_rd;
   logic             lvl_rd;

   assign acc_en = enh_func_en & ext_access_en;

   fts_level_reg #(
      .ADDR_W   (ADDR_W),
      .LVL_ADDR (LVL_ADDR)
   ) u_lvl_reg (
      .clk    (clk),
      .rst_n  (rst_n),
      .we     (reg_we),
      .addr   (reg_addr),
      .wdata  (reg_wdata),
      .acc_en (acc_en),
      .lvl_q  (lvl_q)
   );

   for (genvar d = 0; d < N_DIR; d++) begin : g_dir
      if (d == int'(DIR_TX)) begin : g_tx
         assign dir_cnt[d] = tx_free;
         fts_level_sel #(.FB_TABLE(TX_FALLBACK)) u_sel (
            .code   (lvl_q.tx_code),
            .fb_sel (tx_fb_sel),
            .level  (dir_lvl[d])
         );
         fts_threshold #(.CNT_W(CNT_W)) u_thr (
            .count     (dir_cnt[d]),
            .level     (dir_lvl[d]),
            .force_hit (1'b0),
            .hit       (dir_hit[d])
         );
      end else begin : g_rx
         assign dir_cnt[d] = rx_used;
         fts_level_sel #(.FB_TABLE(RX_FALLBACK)) u_sel (
            .code   (lvl_q.rx_code),
            .fb_sel (rx_fb_sel),
            .level  (dir_lvl[d])
         );
         fts_threshold #(.CNT_W(CNT_W)) u_thr (
            .count     (dir_cnt[d]),
            .level     (dir_lvl[d]),
            .force_hit (rx_timeout),
            .hit       (dir_hit[d])
         );
      end
   end

   assign tx_lvl  = dir_lvl[int'(DIR_TX)];
   assign rx_lvl  = dir_lvl[int'(DIR_RX)];
   assign tx_trig = dir_hit[int'(DIR_TX)];
   assign rx_trig = dir_hit[int'(DIR_RX)];

   assign stat_byte = {3'b000, rx_trig, 3'b000, tx_trig};
   assign stat_rd   = (reg_addr == STAT_ADDR) && rdy_stat_en && !loopback;
   assign lvl_rd    = (reg_addr == LVL_ADDR) && acc_en;

   always_comb begin
      if (stat_rd)     reg_rdata = stat_byte;
      else if (lvl_rd) reg_rdata = lvl_q;
      else             reg_rdata = ext_rdata;
   end
endmodule

// File: rtl/fts_checker.sv
module fts_checker #(
   parameter int                DEPTH     = 64,
   parameter int                ADDR_W    = 3,
   parameter logic [ADDR_W-1:0] LVL_ADDR  = 3'b110,
   parameter logic [ADDR_W-1:0] STAT_ADDR = 3'b111,
   parameter int                CNT_W     = 7
) (
   input logic                      clk,
   input logic                      rst_n,
   input logic [ADDR_W-1:0]         reg_addr,
   input logic                      reg_we,
   input logic [7:0]                reg_wdata,
   input logic [7:0]                reg_rdata,
   input logic                      enh_func_en,
   input logic                      ext_access_en,
   input logic                      rdy_stat_en,
   input logic                      loopback,
   input logic [CNT_W-1:0]          tx_free,
   input logic [CNT_W-1:0]          rx_used,
   input logic                      rx_timeout,
   input logic                      tx_trig,
   input logic                      rx_trig,
   input logic [fts_pkg::LVL_W-1:0] tx_lvl,
   input logic [fts_pkg::LVL_W-1:0] rx_lvl,
   input fts_pkg::lvl_reg_t         lvl_q
);
   AST_WRITE_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && reg_addr == LVL_ADDR && !(enh_func_en && ext_access_en)) |=> $stable(lvl_q)); // R2
   AST_WRITE_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && reg_addr == LVL_ADDR && enh_func_en && ext_access_en) |=> (lvl_q == $past(reg_wdata))); // R2
   AST_TX_LVL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_lvl[1:0] == 2'b00) && (tx_lvl != 0)); // R3
   AST_RX_LVL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_lvl[1:0] == 2'b00) && (rx_lvl != 0)); // R4
   AST_TX_FULL_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_free == CNT_W'(DEPTH)) |-> tx_trig); // R6
   AST_TX_NO_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_free == '0) |-> !tx_trig); // R6
   AST_RX_TIMEOUT: assert property (@(posedge clk) disable iff (!rst_n)
      rx_timeout |-> rx_trig); // R7
   AST_RX_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_used == '0 && !rx_timeout) |-> !rx_trig); // R7
   AST_STAT_PAD: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_addr == STAT_ADDR && rdy_stat_en && !loopback) |-> ((reg_rdata & 8'hEE) == 8'h00)); // R8
endmodule

bind fifo_trig_status fts_checker #(
   .DEPTH     (DEPTH),
   .ADDR_W    (ADDR_W),
   .LVL_ADDR  (LVL_ADDR),
   .STAT_ADDR (STAT_ADDR),
   .CNT_W     (CNT_W)
) u_fts_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .reg_addr      (reg_addr),
   .reg_we        (reg_we),
   .reg_wdata     (reg_wdata),
   .reg_rdata     (reg_rdata),
   .enh_func_en   (enh_func_en),
   .ext_access_en (ext_access_en),
   .rdy_stat_en   (rdy_stat_en),
   .loopback      (loopback),
   .tx_free       (tx_free),
   .rx_used       (rx_used),
   .rx_timeout    (rx_timeout),
   .tx_trig       (tx_trig),
   .rx_trig       (rx_trig),
   .tx_lvl        (tx_lvl),
   .rx_lvl        (rx_lvl),
   .lvl_q         (lvl_q)
);

// File: tb/fifo_trig_status_tb_top.sv
`timescale 1ns/1ps
module fifo_trig_status_tb_top;
   localparam int DEPTH = 64;
   localparam int CNT_W = 7;
   localparam logic [2:0] LVL_A  = 3'b110;
   localparam logic [2:0] STAT_A = 3'b111;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic             rst_n;
   logic [2:0]       reg_addr;
   logic             reg_we;
   logic [7:0]       reg_wdata;
   logic [7:0]       ext_rdata;
   logic [7:0]       reg_rdata;
   logic             enh_func_en, ext_access_en, rdy_stat_en, loopback;
   logic [CNT_W-1:0] tx_free, rx_used;
   logic             rx_timeout;
   logic [1:0]       tx_fb_sel, rx_fb_sel;
   logic             tx_trig, rx_trig;

   fifo_trig_status dut_i (
      .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
      .reg_wdata(reg_wdata), .ext_rdata(ext_rdata), .reg_rdata(reg_rdata),
      .enh_func_en(enh_func_en), .ext_access_en(ext_access_en),
      .rdy_stat_en(rdy_stat_en), .loopback(loopback), .tx_free(tx_free),
      .rx_used(rx_used), .rx_timeout(rx_timeout), .tx_fb_sel(tx_fb_sel),
      .rx_fb_sel(rx_fb_sel), .tx_trig(tx_trig), .rx_trig(rx_trig)
   );

   // staged stimulus, applied at the falling edge
   bit s_rst_n, s_we, s_ef, s_mc, s_rdy, s_lb, s_to;
   int s_addr, s_wd, s_ext, s_txf, s_rxu, s_txs, s_rxs;

   int model_lvl;
   int n_cmp, n_bad;
   bit done;

   function automatic int fb_level(bit rx, int sel);
      int tx_tab[4] = '{8, 16, 32, 56};
      int rx_tab[4] = '{8, 16, 56, 60};
      return rx ? rx_tab[sel] : tx_tab[sel];
   endfunction

   function automatic int cur_level(bit rx);
      int code = rx ? ((model_lvl >> 4) & 15) : (model_lvl & 15);
      if (code != 0) return code * 4;
      return fb_level(rx, rx ? s_rxs : s_txs);
   endfunction

   task automatic compare(string tag, string what, int act, int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h (t=%0t)", tag, what, act, exp, $time);
      end
   endtask

   task automatic cyc(string tag);
      int exp_tx, exp_rx, exp_rd;
      @(negedge clk);
      rst_n         = s_rst_n;
      reg_addr      = s_addr[2:0];
      reg_we        = s_we;
      reg_wdata     = s_wd[7:0];
      ext_rdata     = s_ext[7:0];
      enh_func_en   = s_ef;
      ext_access_en = s_mc;
      rdy_stat_en   = s_rdy;
      loopback      = s_lb;
      tx_free       = s_txf[CNT_W-1:0];
      rx_used       = s_rxu[CNT_W-1:0];
      rx_timeout    = s_to;
      tx_fb_sel     = s_txs[1:0];
      rx_fb_sel     = s_rxs[1:0];
      #1;
      exp_tx = (s_txf >= cur_level(1'b0)) ? 1 : 0;
      exp_rx = (s_to || s_rxu >= cur_level(1'b1)) ? 1 : 0;
      if (s_addr == int'(STAT_A) && s_rdy && !s_lb)
         exp_rd = (exp_rx << 4) | exp_tx;
      else if (s_addr == int'(LVL_A) && s_ef && s_mc)
         exp_rd = model_lvl;
      else
         exp_rd = s_ext;
      compare(tag, "tx_trig", int'(tx_trig), exp_tx);
      compare(tag, "rx_trig", int'(rx_trig), exp_rx);
      compare(tag, "reg_rdata", int'(reg_rdata), exp_rd);
      @(posedge clk);
      if (!s_rst_n) model_lvl = 0;
      else if (s_we && s_addr == int'(LVL_A) && s_ef && s_mc) model_lvl = s_wd;
   endtask

   task automatic idle_bus();
      s_we = 0; s_addr = 0; s_wd = 0;
   endtask

   task automatic write_lvl(int v);
      s_ef = 1; s_mc = 1; s_we = 1; s_addr = int'(LVL_A); s_wd = v;
      cyc("R2 write");
      idle_bus();
   endtask

   task automatic probe(string tag, int txf, int rxu);
      s_txf = txf; s_rxu = rxu;
      cyc(tag);
   endtask

   initial begin
      s_rst_n = 0; s_we = 0; s_ef = 1; s_mc = 1; s_rdy = 0; s_lb = 0; s_to = 0;
      s_addr = 0; s_wd = 0; s_ext = 8'hA5; s_txf = 0; s_rxu = 0; s_txs = 0; s_rxs = 0;
      model_lvl = 0;
      rst_n = 0; reg_addr = 0; reg_we = 0; reg_wdata = 0; ext_rdata = 0;
      enh_func_en = 0; ext_access_en = 0; rdy_stat_en = 0; loopback = 0;
      tx_free = 0; rx_used = 0; rx_timeout = 0; tx_fb_sel = 0; rx_fb_sel = 0;

      // R1: write during reset ignored, register reads zero
      s_we = 1; s_addr = int'(LVL_A); s_wd = 8'h37;
      cyc("R1"); cyc("R1");
      s_rst_n = 1; idle_bus(); s_addr = int'(LVL_A);
      probe("R1", 8, 8);
      probe("R1", 7, 7);

      // R5: fallback selections around each boundary
      for (int sel = 0; sel < 4; sel++) begin
         s_txs = sel; s_rxs = sel;
         probe("R5", fb_level(0, sel) - 1, fb_level(1, sel) - 1);
         probe("R5", fb_level(0, sel),     fb_level(1, sel));
         probe("R5", fb_level(0, sel) + 1, fb_level(1, sel) + 1);
      end

      // R2: blocked writes, then read back with access enabled
      s_ef = 0; s_mc = 1; s_we = 1; s_addr = int'(LVL_A); s_wd = 8'h55; cyc("R2 blocked");
      s_ef = 1; s_mc = 0; s_wd = 8'h99; cyc("R2 blocked");
      s_ef = 0; s_mc = 0; s_wd = 8'hFF; cyc("R2 blocked");
      idle_bus(); s_ef = 1; s_mc = 1; s_addr = int'(LVL_A);
      probe("R2 readback", 8, 8);
      write_lvl(8'h21);
      s_addr = int'(LVL_A); probe("R2 readback", 4, 8);

      // R3: every transmit code
      for (int n = 1; n < 16; n++) begin
         write_lvl(n);
         s_addr = int'(LVL_A);
         probe("R3", 4 * n - 1, 0);
         probe("R3", 4 * n,     0);
         probe("R3", 4 * n + 1, 0);
      end
      // R4: every receive code
      for (int n = 1; n < 16; n++) begin
         write_lvl(n << 4);
         s_addr = int'(LVL_A);
         probe("R4", 0, 4 * n - 1);
         probe("R4", 0, 4 * n);
         probe("R4", DEPTH, 4 * n + 1);
      end

      // R7: timeout forces the receive flag
      write_lvl(8'hF0);
      s_to = 1; probe("R7", 0, 0); probe("R7", 0, 59);
      s_to = 0; probe("R7", 0, 59); probe("R7", 0, 60);

      // R8/R9: status read gating and passthrough
      s_ext = 8'h5A;
      for (int k = 0; k < 4; k++) begin
         s_rdy = k[0]; s_lb = k[1]; s_addr = int'(STAT_A);
         probe("R8", 30, 61);
         probe("R9", 3, 2);
         s_to = 1; probe("R8", 64, 0); s_to = 0;
      end
      s_rdy = 1; s_lb = 0;
      s_we = 1; s_addr = int'(STAT_A); s_wd = 8'hFF; probe("R9", 0, 0);
      idle_bus(); s_ef = 0; s_addr = int'(LVL_A); probe("R9", 10, 10);
      s_ef = 1; s_addr = 2; probe("R9", 10, 10);

      // R10: mixed random traffic, counts change every cycle
      for (int i = 0; i < 3000; i++) begin
         s_ef  = ($urandom % 4) != 0;
         s_mc  = ($urandom % 4) != 0;
         s_rdy = $urandom % 2;
         s_lb  = ($urandom % 4) == 0;
         s_to  = ($urandom % 8) == 0;
         s_we  = ($urandom % 6) == 0;
         s_addr = ($urandom % 2) ? int'(STAT_A - ($urandom % 2)) : int'($urandom % 8);
         s_wd  = $urandom % 256;
         s_ext = $urandom % 256;
         s_txs = $urandom % 4;
         s_rxs = $urandom % 4;
         s_txf = $urandom % (DEPTH + 1);
         s_rxu = $urandom % (DEPTH + 1);
         cyc("R10");
      end

      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: actual running expected finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end
endmodule